// File: doc/BRIEF.md
# Energy Lookup Conversion Unit

This block turns a filtered calorimeter energy sample of ten bits into an eight-bit transverse-energy code. One output count stands for 0.25 GeV, and code 255 is the top of the scale at 61.75 GeV. The conversion moves the zero-energy level from the input scale to the output scale. It then stretches the distance above that level by a slope that each channel sets for itself: code = ped_out + slope x (sample - ped_in). With the standard settings, an empty tower reads 50 at the input and must give 8 at the output.

A host writes one coefficient set per channel over a simple write port: a slope, an input pedestal and an output pedestal. The upstream logic flattens the channel coordinates (tower type, eta sign, eta magnitude, phi) into a channel index. During running, the block takes one sample per clock along with its channel index. Two clocks later it returns the code, which carries a valid strobe and a flag that marks an illegal slope.

The result is computed directly with a fixed-point multiply, so no lookup RAM needs to be filled. Samples below the input pedestal clamp to the output pedestal. Results above full scale saturate.

Top module: `elc_convert`

## Requirements
- R1: After reset, every channel holds slope 1638 (0.4 in the 12-fractional-bit format), input pedestal 50 and output pedestal 8.
- R2: The slope field is 13 bits wide, unsigned, with 12 fractional bits. The code is ped_out + floor((d x slope + 2048) / 4096), where d = sample - ped_in. The product is therefore rounded to nearest, and exact halves round up.
- R3: A sample equal to the channel's input pedestal yields the channel's output pedestal (50 gives 8 with the reset settings).
- R4: A sample below the input pedestal yields the output pedestal exactly. The difference never wraps.
- R5: Any result above 255 is output as 255.
- R6: A sample presented with smp_valid high appears on et_code with et_valid high exactly two clocks later. When smp_valid is low, et_valid is low two clocks later.
- R7: et_slope_err is high together with a result whenever the channel's slope is 4096 (1.0) or more, that is, whenever bit 12 of the slope field is set. At 4095 it is low. The code is still computed and saturated as usual.
- R8: A configuration write changes only the addressed channel.
- R9: A configuration write applies to samples presented on later cycles. A sample presented in the same cycle as the write uses the old coefficients.
- R10: During and right after reset, et_valid, et_code and et_slope_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write the coefficient set for cfg_chan |
| cfg_chan | input | CHAN_W | Channel being configured |
| cfg_slope | input | 13 | Slope, unsigned, 12 fractional bits |
| cfg_ped_in | input | 10 | Zero-energy level on the input scale |
| cfg_ped_out | input | 8 | Zero-energy level on the output scale |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | CHAN_W | Channel of the sample |
| smp_energy | input | 10 | Filtered energy sample |
| et_valid | output | 1 | Result strobe, two clocks after smp_valid |
| et_code | output | 8 | Transverse-energy code, 0.25 GeV per count |
| et_slope_err | output | 1 | Result came from a channel with slope of 1.0 or more |

## Verification
The first samples sit at, just below and far below the pedestal. This separates a correct clamp from a wrapped subtraction. With a slope of exactly one half, consecutive samples place the raw product on whole, half and one-and-a-half counts, which shows whether the design rounds, truncates or rounds halves down. Samples on each side of the 255 boundary, and one at the input maximum, separate saturation from wrap-around. A back-to-back stream over channels with different coefficients, plus a write in the same cycle as a sample, shows that the latency holds and that coefficients do not leak between channels or arrive early.

// File: rtl/elc_pkg.sv
package elc_pkg;

    localparam int IN_W    = 10;
    localparam int OUT_W   = 8;
    localparam int FRAC_W  = 12;
    localparam int SLOPE_W = FRAC_W + 1;
    localparam int PROD_W  = IN_W + SLOPE_W;
    localparam int RND_W   = PROD_W + 1 - FRAC_W;
    localparam int SUM_W   = RND_W + 1;

    localparam logic [SLOPE_W-1:0] SLOPE_ONE   = SLOPE_W'(1 << FRAC_W);
    localparam logic [SLOPE_W-1:0] SLOPE_RESET = SLOPE_W'(1638);
    localparam logic [IN_W-1:0]    PED_IN_RST  = IN_W'(50);
    localparam logic [OUT_W-1:0]   PED_OUT_RST = OUT_W'(8);
    localparam logic [OUT_W-1:0]   CODE_MAX    = '1;

    typedef struct packed {
        logic [SLOPE_W-1:0] slope;
        logic [IN_W-1:0]    ped_in;
        logic [OUT_W-1:0]   ped_out;
    } coef_t;

    localparam coef_t COEF_RESET = '{slope: SLOPE_RESET, ped_in: PED_IN_RST, ped_out: PED_OUT_RST};

    typedef struct packed {
        logic               vld;
        logic               bad;
        logic [IN_W-1:0]    delta;
        logic [SLOPE_W-1:0] slope;
        logic [OUT_W-1:0]   ped_out;
    } stage1_t;

    typedef struct packed {
        logic             vld;
        logic             bad;
        logic [OUT_W-1:0] code;
    } result_t;

    function automatic logic [IN_W-1:0] above_ped(input logic [IN_W-1:0] x,
                                                   input logic [IN_W-1:0] ped);
        return (x > ped) ? x - ped : '0;
    endfunction

    function automatic logic [RND_W-1:0] scale_round(input logic [IN_W-1:0] d,
                                                      input logic [SLOPE_W-1:0] s);
        logic [PROD_W:0] p;
        p = (PROD_W+1)'(d) * (PROD_W+1)'(s) + (PROD_W+1)'(1 << (FRAC_W - 1));
        return p[PROD_W:FRAC_W];
    endfunction

    function automatic logic [OUT_W-1:0] clip_code(input logic [SUM_W-1:0] v);
        return (v > SUM_W'(CODE_MAX)) ? CODE_MAX : v[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/elc_coef_table.sv
module elc_coef_table
    import elc_pkg::*;
#(
    parameter int CHAN_W = 5,
    localparam int NCHAN = 1 << CHAN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CHAN_W-1:0] wr_chan,
    input  coef_t             wr_coef,
    input  logic [CHAN_W-1:0] rd_chan,
    output coef_t             rd_coef
);

    coef_t tbl [NCHAN];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCHAN; i++) tbl[i] <= COEF_RESET;
        end else if (we) begin
            tbl[wr_chan] <= wr_coef;
        end
    end

    assign rd_coef = tbl[rd_chan];

    // R9: a write is visible in the addressed entry on the next cycle
    p_write_lands_r9: assert property (@(posedge clk) disable iff (rst)
        we |=> tbl[$past(wr_chan)] == $past(wr_coef));

endmodule

// File: rtl/elc_datapath.sv
module elc_datapath
    import elc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_vld,
    input  logic [IN_W-1:0] in_x,
    input  coef_t           coef,
    output result_t         res
);

    stage1_t s1;
    logic [RND_W-1:0] rnd;
    logic [SUM_W-1:0] sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld     <= in_vld;
            s1.bad     <= coef.slope[SLOPE_W-1];
            s1.delta   <= above_ped(in_x, coef.ped_in);
            s1.slope   <= coef.slope;
            s1.ped_out <= coef.ped_out;
        end
    end

    always_comb begin
        rnd = scale_round(s1.delta, s1.slope);
        sum = SUM_W'(s1.ped_out) + SUM_W'(rnd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else begin
            res.vld  <= s1.vld;
            res.bad  <= s1.bad;
            res.code <= clip_code(sum);
        end
    end

    // R6: valid travels one stage per clock
    p_valid_in_r6: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> s1.vld);
    p_valid_out_r6: assert property (@(posedge clk) disable iff (rst)
        s1.vld |=> res.vld);
    p_idle_out_r6: assert property (@(posedge clk) disable iff (rst)
        !s1.vld |=> !res.vld);
    // R4: zero distance above the pedestal gives the output pedestal
    p_clamp_floor_r4: assert property (@(posedge clk) disable iff (rst)
        (s1.vld && s1.delta == '0) |=> res.code == $past(s1.ped_out));
    // R5: the code never falls below the output pedestal
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
        s1.vld |=> res.code >= $past(s1.ped_out));
    // R7: error flag follows the slope range
    p_slope_flag_r7: assert property (@(posedge clk) disable iff (rst)
        s1.vld |=> res.bad == ($past(s1.slope) >= SLOPE_ONE));

endmodule

// File: rtl/elc_convert.sv
module elc_convert
    import elc_pkg::*;
#(
    parameter int CHAN_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic [12:0]       cfg_slope,
    input  logic [9:0]        cfg_ped_in,
    input  logic [7:0]        cfg_ped_out,
    input  logic              smp_valid,
    input  logic [CHAN_W-1:0] smp_chan,
    input  logic [9:0]        smp_energy,
    output logic              et_valid,
    output logic [7:0]        et_code,
    output logic              et_slope_err
);

    coef_t   wr_coef;
    coef_t   rd_coef;
    result_t res;

    assign wr_coef = '{slope: cfg_slope, ped_in: cfg_ped_in, ped_out: cfg_ped_out};

    elc_coef_table #(.CHAN_W(CHAN_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .wr_chan (cfg_chan),
        .wr_coef (wr_coef),
        .rd_chan (smp_chan),
        .rd_coef (rd_coef)
    );

    elc_datapath u_dp (
        .clk    (clk),
        .rst    (rst),
        .in_vld (smp_valid),
        .in_x   (smp_energy),
        .coef   (rd_coef),
        .res    (res)
    );

    assign et_valid     = res.vld;
    assign et_code      = res.code;
    assign et_slope_err = res.bad;

    // R10: outputs quiet in the cycle after reset
    p_reset_quiet_r10: assert property (@(posedge clk)
        $past(rst) |-> (!et_valid && et_code == '0 && !et_slope_err));

endmodule

// File: tb/elc_convert_test.sv
module elc_convert_test;

    localparam int CW = 5;
    localparam int NC = 1 << CW;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [CW-1:0] cfg_chan;
    logic [12:0]   cfg_slope;
    logic [9:0]    cfg_ped_in;
    logic [7:0]    cfg_ped_out;
    logic          smp_valid;
    logic [CW-1:0] smp_chan;
    logic [9:0]    smp_energy;
    logic          et_valid;
    logic [7:0]    et_code;
    logic          et_slope_err;

    int checks = 0;
    int failures = 0;
    int sh_slope [NC];
    int sh_pin   [NC];
    int sh_pout  [NC];

    always #10 clk = ~clk;

    elc_convert #(.CHAN_W(CW)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
        .cfg_slope(cfg_slope), .cfg_ped_in(cfg_ped_in), .cfg_ped_out(cfg_ped_out),
        .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_energy(smp_energy),
        .et_valid(et_valid), .et_code(et_code), .et_slope_err(et_slope_err)
    );

    function automatic int model(int x, int s, int pi, int po);
        int d;
        int v;
        d = (x > pi) ? x - pi : 0;
        v = po + (d * s + 2048) / 4096;
        return (v > 255) ? 255 : v;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic cfg_write(int ch, int s, int pi, int po);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = CW'(ch); cfg_slope = 13'(s);
        cfg_ped_in = 10'(pi); cfg_ped_out = 8'(po);
        sh_slope[ch] = s; sh_pin[ch] = pi; sh_pout[ch] = po;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one isolated sample; result checked two clocks after it was taken
    task automatic one_sample(string req, int ch, int x, int exp_code, int exp_bad);
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = CW'(ch); smp_energy = 10'(x);
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        chk(req, "valid", int'(et_valid), 1);
        chk(req, "code", int'(et_code), exp_code);
        chk(req, "slope_err", int'(et_slope_err), exp_bad);
    endtask

    task automatic t_reset();
        rst = 1'b1; cfg_we = 1'b0; smp_valid = 1'b1; smp_chan = '0; smp_energy = 10'd700;
        cfg_chan = '0; cfg_slope = '0; cfg_ped_in = '0; cfg_ped_out = '0;
        for (int c = 0; c < NC; c++) begin
            sh_slope[c] = 1638; sh_pin[c] = 50; sh_pout[c] = 8;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0; smp_valid = 1'b0;
        chk("R10", "valid after reset", int'(et_valid), 0);
        chk("R10", "code after reset", int'(et_code), 0);
        chk("R10", "err after reset", int'(et_slope_err), 0);
        @(negedge clk);
        @(negedge clk);
        chk("R6", "idle valid", int'(et_valid), 0);
    endtask

    task automatic t_defaults();
        one_sample("R3", 0, 50, 8, 0);
        one_sample("R1", 17, 50, 8, 0);
        one_sample("R1", 31, 150, 48, 0);
        @(negedge clk);
        chk("R6", "valid drops", int'(et_valid), 0);
    endtask

    task automatic t_clamp();
        one_sample("R4", 2, 49, 8, 0);
        one_sample("R4", 2, 0, 8, 0);
        cfg_write(9, 3000, 300, 40);
        one_sample("R4", 9, 12, 40, 0);
        one_sample("R3", 9, 300, 40, 0);
    endtask

    task automatic t_rounding();
        cfg_write(3, 2048, 50, 8);
        one_sample("R2", 3, 51, 9, 0);
        one_sample("R2", 3, 52, 9, 0);
        one_sample("R2", 3, 53, 10, 0);
        one_sample("R2", 3, 542, 254, 0);
        one_sample("R5", 3, 543, 255, 0);
        one_sample("R5", 3, 545, 255, 0);
        one_sample("R5", 3, 1023, 255, 0);
        one_sample("R5", 0, 1023, 255, 0);
    endtask

    task automatic t_bad_slope();
        cfg_write(4, 4096, 50, 8);
        one_sample("R7", 4, 60, 18, 1);
        cfg_write(4, 4095, 50, 8);
        one_sample("R7", 4, 60, 18, 0);
        cfg_write(4, 8191, 50, 8);
        one_sample("R7", 4, 60, model(60, 8191, 50, 8), 1);
    endtask

    task automatic t_isolation();
        one_sample("R8", 5, 150, 48, 0);
        one_sample("R8", 10, 150, 48, 0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = CW'(6); cfg_slope = 13'd4095;
        cfg_ped_in = 10'd100; cfg_ped_out = 8'd20;
        smp_valid = 1'b1; smp_chan = CW'(6); smp_energy = 10'd150;
        @(negedge clk);
        cfg_we = 1'b0;
        sh_slope[6] = 4095; sh_pin[6] = 100; sh_pout[6] = 20;
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R9", "old coefficients", int'(et_code), 48);
        @(negedge clk);
        chk("R9", "new coefficients", int'(et_code), 70);
        chk("R9", "new valid", int'(et_valid), 1);
    endtask

    task automatic t_stream();
        int chs [8] = '{0, 3, 7, 4, 7, 9, 6, 3};
        int xs  [8] = '{900, 200, 255, 70, 256, 400, 101, 49};
        int exp_c [8];
        int exp_b [8];
        cfg_write(7, 4095, 0, 0);
        for (int i = 0; i < 8; i++) begin
            exp_c[i] = model(xs[i], sh_slope[chs[i]], sh_pin[chs[i]], sh_pout[chs[i]]);
            exp_b[i] = (sh_slope[chs[i]] >= 4096) ? 1 : 0;
        end
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk("R6", "stream valid", int'(et_valid), 1);
                chk("R2", "stream code", int'(et_code), exp_c[i-2]);
                chk("R7", "stream err", int'(et_slope_err), exp_b[i-2]);
            end
            if (i < 8) begin
                smp_valid = 1'b1; smp_chan = CW'(chs[i]); smp_energy = 10'(xs[i]);
            end else begin
                smp_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk("R6", "stream end", int'(et_valid), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        t_reset();
        t_defaults();
        t_clamp();
        t_rounding();
        t_bad_slope();
        t_isolation();
        t_same_cycle();
        t_stream();
        finish_run();
    end

endmodule